// File: doc/BRIEF.md
# Accumulator Arithmetic Datapath with Bus Drive and Output Port

This block is the 8-bit arithmetic slice of a small bus-oriented processor. It holds an accumulator, a second operand register and an output port register. A two's-complement adder-subtracter sits between the two operand registers. A sequencer elsewhere drives the strobes. Each register captures the shared bus word on a rising clock edge while its active-low load strobe is low. The accumulator, or the adder-subtracter result, is placed on the bus while its active-high enable is high.

The external bus value enters on one port. The word this block drives leaves on another port, together with a flag that says whether the block is driving at all. The output port register copies the accumulator only when the accumulator is being driven during the port load. Each of its flip-flops feeds one line of an eight-line display. Subtraction is carried out as the accumulator plus the inverted operand plus one. Results wrap modulo 2^WIDTH.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the operand register and the output port register to zero. Reset takes priority over every load strobe on the same edge.
- R2: While `acc_ld_n` is low at a rising edge, the accumulator takes `w_in`. While it is high, the accumulator keeps its value whatever `w_in` carries.
- R3: While `b_ld_n` is low at a rising edge, the operand register takes `w_in`. While it is high, the operand register keeps its value.
- R4: With `sum_en` high, `acc_en` low and `sub` low, `w_out` equals (accumulator + operand) mod 2^WIDTH.
- R5: With `sum_en` high, `acc_en` low and `sub` high, `w_out` equals (accumulator + ~operand + 1) mod 2^WIDTH, which is the difference accumulator − operand. A negative difference wraps.
- R6: With `acc_en` high, `w_out` equals the accumulator contents.
- R7: `w_valid` is high exactly when `acc_en` or `sum_en` is high. When neither is high, `w_out` is all zeros.
- R8: A rising edge with `out_ld_n` low and `acc_en` high copies the accumulator into the output port register. Bit i of `port` is driven by flip-flop i of that register.
- R9: `out_ld_n` low while `acc_en` is low has no effect, and `port` keeps its value.
- R10: If `acc_en` and `sum_en` are high together, which is a protocol violation, the accumulator wins the bus.
- R11: All loads use the register values present before the edge. When the accumulator and the output port load on the same edge, the port receives the old accumulator value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| w_in | input | WIDTH | Current value of the shared bus |
| acc_ld_n | input | 1 | Accumulator load, active low |
| b_ld_n | input | 1 | Operand register load, active low |
| out_ld_n | input | 1 | Output port load, active low, qualified by `acc_en` |
| acc_en | input | 1 | Drive the accumulator onto the bus |
| sum_en | input | 1 | Drive the adder-subtracter result onto the bus |
| sub | input | 1 | 0 selects add, 1 selects subtract |
| w_out | output | WIDTH | Word this block drives onto the bus |
| w_valid | output | 1 | High while this block drives the bus |
| port | output | WIDTH | Output port register, one bit per display line |

## Verification
The adder is exercised with small operands that produce no carry, and with operands whose sum wraps past 2^WIDTH. These two cases separate a correctly truncated sum from a stuck or extra carry. Subtraction is tried with the minuend larger than the subtrahend and with it smaller. The borrowing case shows whether the plus-one and the inversion are both present. The remaining patterns pit strobes against each other: reset against pending loads, a port load without the accumulator enable, both enables at once, and an accumulator load on the same edge as a port load. A long run of random strobes and bus words is then compared every cycle against a behavioural model.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    // Internal strobes, all active high after decoding.
    typedef struct packed {
        logic acc_ld;
        logic opb_ld;
        logic port_ld;
        logic acc_drv;
        logic sum_drv;
        logic sub;
    } strobe_t;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_ACC  = 2'd1,
        DRV_SUM  = 2'd2
    } drv_sel_e;

    function automatic strobe_t decode_strobes(
        input logic acc_ld_n,
        input logic b_ld_n,
        input logic out_ld_n,
        input logic acc_en,
        input logic sum_en,
        input logic sub
    );
        strobe_t s;
        s.acc_ld  = ~acc_ld_n;
        s.opb_ld  = ~b_ld_n;
        s.port_ld = ~out_ld_n & acc_en;
        s.acc_drv = acc_en;
        s.sum_drv = sum_en;
        s.sub     = sub;
        return s;
    endfunction

    // The accumulator has priority if both enables are raised.
    function automatic drv_sel_e pick_driver(input logic acc_drv, input logic sum_drv);
        if (acc_drv)
            return DRV_ACC;
        else if (sum_drv)
            return DRV_SUM;
        else
            return DRV_NONE;
    endfunction

endpackage

// File: rtl/dp_load_reg.sv
module dp_load_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;
    logic [W-1:0] carry;

    // Subtraction: invert the operand and inject a carry-in of one.
    assign b_eff    = b ^ {W{sub}};
    assign carry[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[i] ^ b_eff[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
        end
    end

endmodule

// File: rtl/dp_bus_sel.sv
module dp_bus_sel
    import acc_dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_val,
    input  logic [W-1:0] sum_val,
    input  logic         acc_drv,
    input  logic         sum_drv,
    output logic [W-1:0] bus_val,
    output logic         bus_vld
);

    drv_sel_e sel;

    always_comb begin
        sel = pick_driver(acc_drv, sum_drv);
        unique case (sel)
            DRV_ACC: begin
                bus_val = acc_val;
                bus_vld = 1'b1;
            end
            DRV_SUM: begin
                bus_val = sum_val;
                bus_vld = 1'b1;
            end
            default: begin
                bus_val = '0;
                bus_vld = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_dp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] w_in,
    input  logic             acc_ld_n,
    input  logic             b_ld_n,
    input  logic             out_ld_n,
    input  logic             acc_en,
    input  logic             sum_en,
    input  logic             sub,
    output logic [WIDTH-1:0] w_out,
    output logic             w_valid,
    output logic [WIDTH-1:0] port
);

    strobe_t          stb;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] opb_q;
    logic [WIDTH-1:0] sum_y;
    logic [WIDTH-1:0] port_q;

    assign stb = decode_strobes(acc_ld_n, b_ld_n, out_ld_n, acc_en, sum_en, sub);

    dp_load_reg #(.W(WIDTH)) u_acc (
        .clk (clk),
        .rst (rst),
        .ld  (stb.acc_ld),
        .d   (w_in),
        .q   (acc_q)
    );

    dp_load_reg #(.W(WIDTH)) u_opb (
        .clk (clk),
        .rst (rst),
        .ld  (stb.opb_ld),
        .d   (w_in),
        .q   (opb_q)
    );

    // The port copies the accumulator directly, which is the word on the bus.
    dp_load_reg #(.W(WIDTH)) u_port (
        .clk (clk),
        .rst (rst),
        .ld  (stb.port_ld),
        .d   (acc_q),
        .q   (port_q)
    );

    dp_addsub #(.W(WIDTH)) u_alu (
        .a   (acc_q),
        .b   (opb_q),
        .sub (stb.sub),
        .y   (sum_y)
    );

    dp_bus_sel #(.W(WIDTH)) u_drv (
        .acc_val (acc_q),
        .sum_val (sum_y),
        .acc_drv (stb.acc_drv),
        .sum_drv (stb.sum_drv),
        .bus_val (w_out),
        .bus_vld (w_valid)
    );

    assign port = port_q;

endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] w_in,
    input logic         acc_ld_n,
    input logic         b_ld_n,
    input logic         out_ld_n,
    input logic         acc_en,
    input logic         sum_en,
    input logic         sub,
    input logic [W-1:0] w_out,
    input logic         w_valid,
    input logic [W-1:0] port,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] opb_q
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (port == '0 && acc_q == '0 && opb_q == '0));

    // R2
    a_r2_acc_load: assert property (@(posedge clk) disable iff (rst)
        !acc_ld_n |=> acc_q == $past(w_in));

    // R3
    a_r3_opb_load: assert property (@(posedge clk) disable iff (rst)
        !b_ld_n |=> opb_q == $past(w_in));

    // R4
    a_r4_add_result: assert property (@(posedge clk) disable iff (rst)
        (sum_en && !acc_en && !sub) |-> w_out == W'(acc_q + opb_q));

    // R5
    a_r5_sub_result: assert property (@(posedge clk) disable iff (rst)
        (sum_en && !acc_en && sub) |-> w_out == W'(acc_q - opb_q));

    // R6 and R10
    a_r6_acc_drive: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> w_out == acc_q);

    // R7
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !w_valid |-> (w_out == '0 && !acc_en && !sum_en));

    // R8 and R11
    a_r8_port_load: assert property (@(posedge clk) disable iff (rst)
        (!out_ld_n && acc_en) |=> port == $past(w_out));

    // R9
    a_r9_port_hold: assert property (@(posedge clk) disable iff (rst)
        !(!out_ld_n && acc_en) |=> $stable(port));

endmodule

bind acc_datapath acc_datapath_chk #(.W(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .w_in     (w_in),
    .acc_ld_n (acc_ld_n),
    .b_ld_n   (b_ld_n),
    .out_ld_n (out_ld_n),
    .acc_en   (acc_en),
    .sum_en   (sum_en),
    .sub      (sub),
    .w_out    (w_out),
    .w_valid  (w_valid),
    .port     (port),
    .acc_q    (acc_q),
    .opb_q    (opb_q)
);

// File: tb/acc_datapath_test.sv
module acc_datapath_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] w_in;
    logic         acc_ld_n, b_ld_n, out_ld_n, acc_en, sum_en, sub;
    logic [W-1:0] w_out;
    logic         w_valid;
    logic [W-1:0] port;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state.
    int m_acc = 0, m_b = 0, m_port = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_datapath #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .w_in     (w_in),
        .acc_ld_n (acc_ld_n),
        .b_ld_n   (b_ld_n),
        .out_ld_n (out_ld_n),
        .acc_en   (acc_en),
        .sum_en   (sum_en),
        .sub      (sub),
        .w_out    (w_out),
        .w_valid  (w_valid),
        .port     (port)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle: inputs applied after a falling edge, outputs compared
    // mid-low phase, model advanced at the rising edge.
    task automatic step(input bit r, input int bus, input bit al, input bit bl, input bit ol,
                        input bit ae, input bit se, input bit su, input string tag);
        int exp_bus, exp_vld;
        rst = r; w_in = W'(bus); acc_ld_n = al; b_ld_n = bl; out_ld_n = ol;
        acc_en = ae; sum_en = se; sub = su;
        #(CLK_PERIOD/4);
        if (ae)       exp_bus = m_acc;
        else if (se)  exp_bus = su ? ((m_acc - m_b) & 8'hFF) : ((m_acc + m_b) & 8'hFF);
        else          exp_bus = 0;
        exp_vld = (ae || se) ? 1 : 0;
        check(tag, "w_out",   int'(w_out),   exp_bus);
        check(tag, "w_valid", int'(w_valid), exp_vld);
        check(tag, "port",    int'(port),    m_port);
        @(posedge clk);
        if (r) begin
            m_acc = 0; m_b = 0; m_port = 0;
        end else begin
            if (!ol && ae) m_port = m_acc;
            if (!al) m_acc = bus & 8'hFF;
            if (!bl) m_b = bus & 8'hFF;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; w_in = '0; acc_ld_n = 1'b1; b_ld_n = 1'b1; out_ld_n = 1'b1;
        acc_en = 1'b0; sum_en = 1'b0; sub = 1'b0;
        @(negedge clk);
        // R1: reset with every load pending must still clear.
        step(1, 'hFF, 0, 0, 0, 1, 0, 0, "R1");
        step(1, 'hAA, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 'h00, 1, 1, 1, 1, 0, 0, "R1");
        step(0, 'h00, 1, 1, 1, 0, 1, 0, "R1");
        // R2, R3 loads; R7 idle bus
        step(0, 'h35, 0, 1, 1, 0, 0, 0, "R2");
        step(0, 'h12, 1, 0, 1, 0, 0, 0, "R3");
        step(0, 'hEE, 1, 1, 1, 0, 0, 0, "R7");
        // R4 add without carry, R5 subtract without borrow
        step(0, 'h00, 1, 1, 1, 0, 1, 0, "R4");
        step(0, 'h00, 1, 1, 1, 0, 1, 1, "R5");
        // R5 borrowing case 0x35 - 0x50
        step(0, 'h50, 1, 0, 1, 0, 0, 0, "R3");
        step(0, 'h00, 1, 1, 1, 0, 1, 1, "R5");
        // R4 wrap: 0xF0 + 0x20
        step(0, 'hF0, 0, 1, 1, 0, 0, 0, "R2");
        step(0, 'h20, 1, 0, 1, 0, 0, 0, "R3");
        step(0, 'h00, 1, 1, 1, 0, 1, 0, "R4");
        // R2 hold with garbage on the bus
        step(0, 'h5A, 1, 1, 1, 1, 0, 0, "R2");
        // R6 drive, R8 port load
        step(0, 'h00, 1, 1, 0, 1, 0, 0, "R8");
        step(0, 'h00, 1, 1, 1, 0, 0, 0, "R8");
        // R9 port strobe without accumulator enable
        step(0, 'h77, 0, 1, 0, 0, 0, 0, "R9");
        step(0, 'h00, 1, 1, 0, 0, 1, 0, "R9");
        step(0, 'h00, 1, 1, 1, 1, 0, 0, "R6");
        // R10 both enables
        step(0, 'h00, 1, 1, 1, 1, 1, 1, "R10");
        // R11 accumulator and port load on one edge
        step(0, 'hC3, 0, 1, 0, 1, 0, 0, "R11");
        step(0, 'h00, 1, 1, 1, 1, 0, 0, "R11");
        // Random traffic against the model
        for (int i = 0; i < 300; i++) begin
            int dbus;
            bit ae;
            dbus = $urandom_range(0, 255);
            ae   = 1'($urandom_range(0, 1));
            step(0, dbus, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ae, ae ? 1'b0 : 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), "R4");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule